// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Assembler

This block sits between an instruction fetch stream and a decoder. It takes 16-bit instruction parcels, one per accepted input handshake, in increasing halfword address order. From the low-order prefix bits of the first parcel it works out how many parcels the instruction occupies. It then gathers that many parcels into one wide register and presents the finished instruction, its length in parcels and an illegal flag on a valid/ready output.

Two parameters shape it. One is the widest instruction kept, a multiple of 16 bits from 32 to 176. The other says whether 16-bit compressed instructions exist. Encodings longer than the kept width are still consumed in full, so parcel alignment survives, but they are marked illegal. A synchronous flush throws away whatever is in flight, for use after a branch redirect.

Top module: `parcel_assembler`

## Requirements
- R1: With parcel bits [1:0] not equal to 11, the instruction is 1 parcel (compressed support on). With [1:0]=11 and [4:2] not 111 it is 2 parcels. With [5:0]=011111 it is 3 parcels. With [6:0]=0111111 it is 4 parcels.
- R2: With [6:0]=1111111, the field n in bits [14:12] gives 5+n parcels when n is below 7. When n is 7 the encoding is reserved: it is illegal and is taken as ILEN/16 parcels long.
- R3: The k-th parcel of an instruction (k from 0) appears at out_instr bits [16k+15:16k]. Every bit above the received parcels reads zero. out_len gives the decoded length in parcels.
- R4: A first parcel of all zeros is illegal. It is 1 parcel long with compressed support and 2 parcels long without it.
- R5: Without compressed support, a first parcel whose bits [1:0] are not 11 is illegal and 2 parcels long.
- R6: A decoded length above ILEN/16 parcels is illegal. All of its parcels are still consumed, and only the first ILEN/16 parcels are kept.
- R7: An instruction whose ILEN bits are all ones is reported illegal, with a length of ILEN/16 parcels.
- R8: While out_valid is high and out_ready is low, in_ready is low and out_instr, out_len and out_illegal hold their values.
- R9: While flush is high, in_ready is low. The cycle after flush, out_valid is low, any partial or waiting instruction is gone, and the next accepted parcel starts a new instruction.
- R10: When an output handshake and the first parcel of the next instruction occur in the same cycle, both are taken. Single-parcel instructions then pass at one per cycle.
- R11: During and right after reset, out_valid is low and in_ready is high.
- R12: out_valid rises on the clock edge that accepts the last parcel of an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of all in-flight state |
| in_valid | input | 1 | A parcel is offered |
| in_ready | output | 1 | The block accepts the offered parcel |
| in_parcel | input | 16 | Instruction parcel, lowest address first |
| out_valid | output | 1 | An assembled instruction is presented |
| out_ready | input | 1 | The consumer takes the instruction |
| out_instr | output | ILEN_BITS | Assembled instruction, zero above its parcels |
| out_len | output | 4 | Decoded length in parcels (1 to 11) |
| out_illegal | output | 1 | Encoding is illegal or too long to keep |

## Verification
The hold-while-stalled property assumes flush is low in the stalled cycle, since a flush may legally drop a waiting instruction. The property that a flush clears the output assumes nothing about in_valid. The stimulus keeps flush out of the random traffic and uses it only in directed sequences, so every random instruction must arrive intact. out_ready and in_valid are random each cycle and may drop without a completed handshake, which the block must tolerate.

// File: rtl/pa_pkg.sv
`timescale 1ns/1ps
package pa_pkg;
   localparam int PARCEL_W = 16;
   localparam int LEN_W    = 4;
   localparam int LONGEST  = 11;
   typedef logic [LEN_W-1:0] plen_t;
endpackage

// File: rtl/pa_len_decode.sv
`timescale 1ns/1ps
module pa_len_decode
   import pa_pkg::*;
#(
   parameter int MAX_P          = 11,
   parameter bit HAS_COMPRESSED = 1'b1
) (
   input  logic [PARCEL_W-1:0] head_i,
   output plen_t               len_o,
   output logic                ill_o
);
   localparam plen_t MAX_L = plen_t'(MAX_P);

   plen_t short_len;
   logic  short_ill;
   logic  is_zero;
   plen_t raw_len;
   logic  raw_ill;

   assign is_zero = ~|head_i;

   generate
      if (HAS_COMPRESSED) begin : g_short_c
         assign short_len = plen_t'(1);
         assign short_ill = 1'b0;
      end else begin : g_short_nc
         assign short_len = plen_t'(2);
         assign short_ill = 1'b1;
      end
   endgenerate

   always_comb begin
      raw_ill = 1'b0;
      if (head_i[1:0] != 2'b11) begin
         raw_len = short_len;
         raw_ill = short_ill;
      end else if (head_i[4:2] != 3'b111) begin
         raw_len = plen_t'(2);
      end else if (!head_i[5]) begin
         raw_len = plen_t'(3);
      end else if (!head_i[6]) begin
         raw_len = plen_t'(4);
      end else if (head_i[14:12] != 3'b111) begin
         raw_len = plen_t'(5) + plen_t'(head_i[14:12]);
      end else begin
         raw_len = MAX_L;
         raw_ill = 1'b1;
      end
   end

   assign len_o = raw_len;
   assign ill_o = raw_ill | is_zero | (raw_len > MAX_L);

   always_comb begin
      assert_len_nonzero_R1: assert (raw_len != '0);
   end
endmodule

// File: rtl/pa_parcel_store.sv
`timescale 1ns/1ps
module pa_parcel_store
   import pa_pkg::*;
#(
   parameter int ILEN_BITS = 176
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_first,
   input  plen_t                wr_idx,
   input  logic [PARCEL_W-1:0]  wr_data,
   output logic [ILEN_BITS-1:0] flat_o
);
   localparam int SLOTS = ILEN_BITS / PARCEL_W;

   genvar gi;
   generate
      for (gi = 0; gi < SLOTS; gi++) begin : g_slot
         logic [PARCEL_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= '0;
            end else if (wr_en) begin
               if (wr_first) begin
                  slot_q <= (gi == 0) ? wr_data : '0;
               end else if (int'(wr_idx) == gi) begin
                  slot_q <= wr_data;
               end
            end
         end
         assign flat_o[gi*PARCEL_W +: PARCEL_W] = slot_q;
      end
   endgenerate

   assert_upper_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_first) |=> (flat_o[ILEN_BITS-1:PARCEL_W] == '0));
endmodule

// File: rtl/parcel_assembler.sv
`timescale 1ns/1ps
module parcel_assembler
   import pa_pkg::*;
#(
   parameter int ILEN_BITS      = 176,
   parameter bit HAS_COMPRESSED = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [15:0]          in_parcel,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [ILEN_BITS-1:0] out_instr,
   output logic [3:0]           out_len,
   output logic                 out_illegal
);
   localparam int    MAX_P = ILEN_BITS / PARCEL_W;
   localparam plen_t MAX_L = plen_t'(MAX_P);

   generate
      if ((ILEN_BITS % PARCEL_W) != 0 || ILEN_BITS < 32 || MAX_P > LONGEST) begin : g_bad_ilen
         $error("parcel_assembler: ILEN_BITS must be a multiple of 16 from 32 to 176");
      end
   endgenerate

   logic  busy_q, ovld_q, ill_q;
   plen_t cnt_q, len_q;
   plen_t dec_len;
   logic  dec_ill;
   logic  accept, take_out, last_beat;

   pa_len_decode #(
      .MAX_P          (MAX_P),
      .HAS_COMPRESSED (HAS_COMPRESSED)
   ) u_decode (
      .head_i (in_parcel),
      .len_o  (dec_len),
      .ill_o  (dec_ill)
   );

   pa_parcel_store #(
      .ILEN_BITS (ILEN_BITS)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (accept),
      .wr_first (!busy_q),
      .wr_idx   (cnt_q),
      .wr_data  (in_parcel),
      .flat_o   (out_instr)
   );

   assign in_ready  = !flush && (!ovld_q || out_ready);
   assign accept    = in_valid && in_ready;
   assign take_out  = ovld_q && out_ready;
   assign last_beat = busy_q && ((cnt_q + plen_t'(1)) == len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ovld_q <= 1'b0;
         ill_q  <= 1'b0;
         cnt_q  <= '0;
         len_q  <= '0;
      end else if (flush) begin
         busy_q <= 1'b0;
         ovld_q <= 1'b0;
      end else begin
         if (take_out) begin
            ovld_q <= 1'b0;
         end
         if (accept) begin
            if (!busy_q) begin
               len_q <= dec_len;
               ill_q <= dec_ill;
               cnt_q <= plen_t'(1);
               if (dec_len == plen_t'(1)) begin
                  ovld_q <= 1'b1;
               end else begin
                  busy_q <= 1'b1;
               end
            end else begin
               cnt_q <= cnt_q + plen_t'(1);
               if (last_beat) begin
                  busy_q <= 1'b0;
                  ovld_q <= 1'b1;
               end
            end
         end
      end
   end

   assign out_valid   = ovld_q;
   assign out_len     = len_q;
   assign out_illegal = ill_q;

   assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_instr)
                                               && $stable(out_len) && $stable(out_illegal)));

   assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!out_valid && !busy_q));

   assert_len_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_len != '0 && out_len <= plen_t'(LONGEST)));

   assert_too_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_len > MAX_L)) |-> out_illegal);

   assert_all_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (&out_instr)) |-> out_illegal);

   assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q < len_q && !out_valid));
endmodule

// File: tb/parcel_assembler_tb_top.sv
`timescale 1ns/1ps
module parcel_assembler_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic out_ready = 1'b0;
   logic iv0 = 1'b0, iv1 = 1'b0;
   logic [15:0] ip0 = '0, ip1 = '0;
   logic ir0, ir1, ov0, ov1, oil0, oil1;
   logic [175:0] oi0;
   logic [63:0]  oi1;
   logic [3:0]   ol0, ol1;

   int  nchk = 0;
   int  nfail = 0;
   bit  done = 1'b0;

   logic [15:0]  pq0[$], pq1[$];
   logic [175:0] ei0[$], ei1[$];
   int           el0[$], el1[$];
   bit           eb0[$], eb1[$];
   string        et0[$], et1[$];

   always #5 clk = ~clk;

   parcel_assembler #(.ILEN_BITS(176), .HAS_COMPRESSED(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(iv0), .in_ready(ir0), .in_parcel(ip0),
      .out_valid(ov0), .out_ready(out_ready),
      .out_instr(oi0), .out_len(ol0), .out_illegal(oil0));

   parcel_assembler #(.ILEN_BITS(64), .HAS_COMPRESSED(1'b0)) dut_nc_i (
      .clk(clk), .rst_n(rst_n), .flush(1'b0),
      .in_valid(iv1), .in_ready(ir1), .in_parcel(ip1),
      .out_valid(ov1), .out_ready(out_ready),
      .out_instr(oi1), .out_len(ol1), .out_illegal(oil1));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [175:0] act, input logic [175:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Expected length from the first parcel, written from the requirements
   function automatic int blen(input logic [15:0] p, input bit hc, input int maxp, output bit ill);
      int n;
      ill = 1'b0;
      if (p[1:0] != 2'b11) begin
         n = hc ? 1 : 2;
         ill = !hc || (p == 16'h0000);
      end else if (p[4:2] != 3'b111) n = 2;
      else if (p[5] == 1'b0) n = 3;
      else if (p[6] == 1'b0) n = 4;
      else if (p[14:12] != 3'b111) n = 5 + int'(p[14:12]);
      else begin
         n = maxp;
         ill = 1'b1;
      end
      if (n > maxp) ill = 1'b1;
      return n;
   endfunction

   task automatic add_instr(input int lane, input int kind);
      logic [15:0]  p0, par;
      logic [175:0] e;
      logic [31:0]  r;
      int           n, maxp;
      bit           ill, hc;
      string        t;
      hc = (lane == 0);
      maxp = hc ? 11 : 4;
      r = $urandom;
      p0 = r[31:16];
      case (kind)
         0: p0[1:0] = 2'(r % 3);
         1: begin p0[1:0] = 2'b11; p0[4:2] = 3'(r % 7); end
         2: p0[5:0] = 6'b011111;
         3: p0[6:0] = 7'b0111111;
         4: begin p0[6:0] = 7'h7f; p0[14:12] = r[2:0]; end
         5: p0 = 16'h0000;
         6: p0 = 16'hffff;
         default: ;
      endcase
      n = blen(p0, hc, maxp, ill);
      e = '0;
      for (int k = 0; k < n; k++) begin
         par = (k == 0) ? p0 : ((kind == 6) ? 16'hffff : 16'($urandom));
         if (k < maxp) e[16*k +: 16] = par;
         if (lane == 0) pq0.push_back(par); else pq1.push_back(par);
      end
      case (kind)
         0: t = hc ? "R1" : "R5";
         4: t = "R2";
         5: t = "R4";
         6: t = "R7";
         7: t = "R3";
         default: t = "R1";
      endcase
      if (n > maxp && kind != 6) t = "R6";
      if (lane == 0) begin
         ei0.push_back(e); el0.push_back(n); eb0.push_back(ill); et0.push_back(t);
      end else begin
         ei1.push_back(e); el1.push_back(n); eb1.push_back(ill); et1.push_back(t);
      end
   endtask

   task automatic drv(input bit v, input logic [15:0] p, input bit ordy, input bit fl);
      @(negedge clk);
      iv0 = v; ip0 = p; out_ready = ordy; flush = fl; iv1 = 1'b0;
      #1;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [175:0] e;
      int l;
      bit b;
      string t;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk(!ov0 && ir0, "R11", "reset state lane0", 176'({ov0, ir0}), 176'(2'b01));
      chk(!ov1 && ir1, "R11", "reset state lane1", 176'({ov1, ir1}), 176'(2'b01));
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!ov0 && ir0, "R11", "after reset", 176'({ov0, ir0}), 176'(2'b01));

      // directed corners first, then random traffic
      add_instr(0, 5); add_instr(0, 6); add_instr(0, 4); add_instr(0, 2); add_instr(0, 3);
      add_instr(1, 5); add_instr(1, 0); add_instr(1, 6); add_instr(1, 4); add_instr(1, 2);
      for (int i = 0; i < 300; i++) add_instr(0, int'($urandom % 8));
      for (int i = 0; i < 150; i++) add_instr(1, int'($urandom % 8));

      while (pq0.size() != 0 || ei0.size() != 0 || pq1.size() != 0 || ei1.size() != 0) begin
         @(negedge clk);
         out_ready = ($urandom % 4) != 0;
         iv0 = (pq0.size() != 0) && (($urandom % 5) != 0);
         ip0 = iv0 ? pq0[0] : 16'($urandom);
         iv1 = (pq1.size() != 0) && (($urandom % 5) != 0);
         ip1 = iv1 ? pq1[0] : 16'($urandom);
         #1;
         if (ov0 && !out_ready) chk(!ir0, "R8", "in_ready during stall lane0", 176'(ir0), 176'(0));
         if (ov1 && !out_ready) chk(!ir1, "R8", "in_ready during stall lane1", 176'(ir1), 176'(0));
         if (ov0 && out_ready) begin
            if (ei0.size() == 0) chk(1'b0, "R3", "unexpected output lane0", oi0, 176'(0));
            else begin
               e = ei0.pop_front(); l = el0.pop_front(); b = eb0.pop_front(); t = et0.pop_front();
               chk(oi0 == e, t, "instr lane0", oi0, e);
               chk(int'(ol0) == l, t, "len lane0", 176'(ol0), 176'(l));
               chk(oil0 == b, t, "illegal lane0", 176'(oil0), 176'(b));
            end
         end
         if (ov1 && out_ready) begin
            if (ei1.size() == 0) chk(1'b0, "R3", "unexpected output lane1", 176'(oi1), 176'(0));
            else begin
               e = ei1.pop_front(); l = el1.pop_front(); b = eb1.pop_front(); t = et1.pop_front();
               chk(176'(oi1) == e, t, "instr lane1", 176'(oi1), e);
               chk(int'(ol1) == l, t, "len lane1", 176'(ol1), 176'(l));
               chk(oil1 == b, t, "illegal lane1", 176'(oil1), 176'(b));
            end
         end
         if (iv0 && ir0) void'(pq0.pop_front());
         if (iv1 && ir1) void'(pq1.pop_front());
      end

      // R10 / R12: two single-parcel instructions back to back
      drv(1'b1, 16'h0004, 1'b1, 1'b0);
      chk(ir0, "R10", "in_ready when idle", 176'(ir0), 176'(1));
      drv(1'b1, 16'h0008, 1'b1, 1'b0);
      chk(ov0 && oi0 == 176'h4, "R12", "output one edge after last parcel", oi0, 176'h4);
      chk(ir0, "R10", "in_ready while output taken", 176'(ir0), 176'(1));
      drv(1'b0, 16'h0000, 1'b1, 1'b0);
      chk(ov0 && oi0 == 176'h8, "R10", "second back-to-back instr", oi0, 176'h8);
      drv(1'b0, 16'h0000, 1'b1, 1'b0);
      chk(!ov0, "R10", "idle after pair", 176'(ov0), 176'(0));

      // R9: flush drops a partial 48-bit instruction
      drv(1'b1, 16'h001f, 1'b1, 1'b0);
      drv(1'b1, 16'haaaa, 1'b1, 1'b0);
      drv(1'b0, 16'h0000, 1'b1, 1'b1);
      chk(!ir0, "R9", "in_ready low during flush", 176'(ir0), 176'(0));
      drv(1'b1, 16'h0013, 1'b1, 1'b0);
      chk(!ov0, "R9", "no output from flushed partial", 176'(ov0), 176'(0));
      drv(1'b1, 16'h5555, 1'b1, 1'b0);
      drv(1'b0, 16'h0000, 1'b1, 1'b0);
      chk(ov0 && oi0 == 176'h5555_0013 && ol0 == 4'd2 && !oil0, "R9",
          "fresh instruction after flush", oi0, 176'h5555_0013);
      drv(1'b0, 16'h0000, 1'b1, 1'b0);

      // R8 then R9: stalled output holds, then flush drops it
      drv(1'b1, 16'h0001, 1'b0, 1'b0);
      drv(1'b0, 16'h0000, 1'b0, 1'b0);
      chk(ov0 && !ir0, "R8", "stall blocks input", 176'({ov0, ir0}), 176'(2'b10));
      drv(1'b1, 16'h0002, 1'b0, 1'b0);
      chk(ov0 && oi0 == 176'h1 && ol0 == 4'd1 && !ir0, "R8", "held output while stalled", oi0, 176'h1);
      drv(1'b0, 16'h0000, 1'b0, 1'b1);
      drv(1'b0, 16'h0000, 1'b1, 1'b0);
      chk(!ov0, "R9", "waiting output dropped by flush", 176'(ov0), 176'(0));
      drv(1'b0, 16'h0000, 1'b1, 1'b0);
      chk(!ov0 && ir0, "R8", "refused parcel left no output", 176'({ov0, ir0}), 176'(2'b01));

      done = 1'b1;
      summary();
      $finish;
   end
endmodule